// File: doc/BRIEF.md
# Debug Serial Port Slave

This block is the target end of a synchronous serial debug link. An external host is always the master and is the only side that drives the serial clock. Every frame is a full-duplex exchange of one 17-bit word: while the host shifts a command in, the block shifts the previously loaded response out. Bit 16 of each word is a status or control flag, bits 15..0 carry data, and the most significant bit goes first.

The whole block runs on the target system clock. The serial clock, data-in and frame-select pins pass through synchronizer flops, and the block detects the serial clock edges from the synchronized copy, so there is no second clock domain. Once 17 bits have arrived, the block hands the command word to the core together with a one-cycle valid strobe. The core supplies the next response as a 16-bit data word, a status bit and a load strobe. If no response has been loaded by the time a frame starts, the block sends a not-ready word.

Top module: `dbg_serial_slave`

## Requirements
- R1: After the active-low synchronous reset, `ser_dout_o` is 1 (the not-ready status bit), `cmd_valid_o` is 0 and `cmd_word_o` is 0.
- R2: Data-in is captured on each detected rising serial clock edge, most significant bit first. After the 17th rising edge, `cmd_word_o` holds the 17 received bits, first bit at bit 16, and `cmd_valid_o` is high for exactly one system clock cycle.
- R3: A load strobe with no frame in progress places bit 16 (the status bit) of the response on `ser_dout_o` on the next system clock cycle. Each later bit, in order 15 down to 0, appears after a detected falling serial clock edge.
- R4: In the same frame, the loaded response is sent while the command is received.
- R5: Status value 0 marks a data word and status value 1 marks a not-ready word. A frame that starts with no loaded response sends 1 followed by sixteen 0 bits.
- R6: When a frame completes, the transmit word returns to the not-ready word, so `ser_dout_o` is 1 until the next load.
- R7: A load strobe while a frame is in progress (one or more bits received) is ignored, and the word being sent is unchanged.
- R8: While the frame select is low, serial clock edges are ignored. A partial frame is discarded: the bit count restarts at 0, no valid strobe is issued, and the transmit word returns to the not-ready word.
- R9: `ser_dout_o` changes only after a detected falling edge, a load, a frame completion or an abort. It is never changed by a rising edge in mid-frame.
- R10: Command reception is correct at the highest serial rate, a serial clock period of two system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk_i | input | 1 | Serial clock from the host |
| ser_din_i | input | 1 | Serial data from the host |
| ser_sel_i | input | 1 | Frame select from the host, active high |
| ser_dout_o | output | 1 | Serial data to the host |
| cmd_word_o | output | 17 | Last received command word, flag at bit 16 |
| cmd_valid_o | output | 1 | One-cycle strobe for a new command word |
| rsp_data_i | input | 16 | Response data word |
| rsp_stat_i | input | 1 | Response status bit (0 data, 1 not-ready) |
| rsp_load_i | input | 1 | Load strobe for the response |

## Verification
The hardest situations to reach from the ports are a load strobe arriving in the middle of a frame and a frame aborted partway through. To reach the first, the bench raises the load strobe with a different response word after eight bits have been received, then checks that every remaining output bit still follows the original word. To reach the second, it loads a response, shifts six bits, drops the select and toggles the serial clock while the select is low, then runs a complete frame. That frame must produce exactly one command and must send the not-ready word. The highest serial rate is reached by driving each serial clock level for a single system clock cycle.

// File: rtl/dss_pkg.sv
package dss_pkg;
    localparam int DSS_DATA_W = 16;

    typedef enum logic {
        DSS_ST_DATA     = 1'b0,
        DSS_ST_NOTREADY = 1'b1
    } dss_stat_e;
endpackage

// File: rtl/dss_sync.sv
module dss_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= (s == 0) ? d_i : stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dss_edge.sv
module dss_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/dss_engine.sv
module dss_engine
    import dss_pkg::*;
#(
    parameter int DATA_W  = DSS_DATA_W,
    localparam int FRAME_W = DATA_W + 1,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_i,
    input  logic               din_i,
    input  logic               rise_i,
    input  logic               fall_i,
    input  logic [DATA_W-1:0]  rsp_data_i,
    input  logic               rsp_stat_i,
    input  logic               rsp_load_i,
    output logic               dout_o,
    output logic [FRAME_W-1:0] cmd_word_o,
    output logic               cmd_valid_o,
    output logic [CNT_W-1:0]   bit_cnt_o
);
    localparam logic [FRAME_W-1:0] NOT_READY = {DSS_ST_NOTREADY, {DATA_W{1'b0}}};
    localparam logic [CNT_W-1:0]   LAST_BIT  = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [FRAME_W-1:0] rx;
        logic [FRAME_W-1:0] tx;
        logic [FRAME_W-1:0] cmd;
        logic [CNT_W-1:0]   cnt;
        logic               vld;
    } eng_st_t;

    eng_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;

        if (rsp_load_i && st_q.cnt == '0) begin
            st_d.tx = {rsp_stat_i, rsp_data_i};
        end

        if (!sel_i) begin
            if (st_q.cnt != '0) begin
                st_d.cnt = '0;
                st_d.rx  = '0;
                st_d.tx  = NOT_READY;
            end
        end else begin
            if (rise_i) begin
                if (st_q.cnt == LAST_BIT) begin
                    st_d.cmd = {st_q.rx[FRAME_W-2:0], din_i};
                    st_d.vld = 1'b1;
                    st_d.cnt = '0;
                    st_d.rx  = '0;
                    st_d.tx  = NOT_READY;
                end else begin
                    st_d.rx  = {st_q.rx[FRAME_W-2:0], din_i};
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            if (fall_i && st_q.cnt != '0) begin
                st_d.tx = {st_q.tx[FRAME_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rx  <= '0;
            st_q.tx  <= NOT_READY;
            st_q.cmd <= '0;
            st_q.cnt <= '0;
            st_q.vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o      = st_q.tx[FRAME_W-1];
    assign cmd_word_o  = st_q.cmd;
    assign cmd_valid_o = st_q.vld;
    assign bit_cnt_o   = st_q.cnt;
endmodule

// File: rtl/dbg_serial_slave.sv
module dbg_serial_slave
    import dss_pkg::*;
#(
    parameter int DATA_W      = DSS_DATA_W,
    parameter int SYNC_STAGES = 2,
    localparam int FRAME_W    = DATA_W + 1,
    localparam int CNT_W      = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk_i,
    input  logic               ser_din_i,
    input  logic               ser_sel_i,
    output logic               ser_dout_o,
    output logic [FRAME_W-1:0] cmd_word_o,
    output logic               cmd_valid_o,
    input  logic [DATA_W-1:0]  rsp_data_i,
    input  logic               rsp_stat_i,
    input  logic               rsp_load_i
);
    logic [2:0]       pins_s;
    logic             sclk_s, din_s, sel_s;
    logic             rise_w, fall_w;
    logic [CNT_W-1:0] bit_cnt;

    dss_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ser_sel_i, ser_din_i, ser_clk_i}),
        .q_o   (pins_s)
    );

    assign sclk_s = pins_s[0];
    assign din_s  = pins_s[1];
    assign sel_s  = pins_s[2];

    dss_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sclk_s),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    dss_engine #(.DATA_W(DATA_W)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel_s),
        .din_i       (din_s),
        .rise_i      (rise_w),
        .fall_i      (fall_w),
        .rsp_data_i  (rsp_data_i),
        .rsp_stat_i  (rsp_stat_i),
        .rsp_load_i  (rsp_load_i),
        .dout_o      (ser_dout_o),
        .cmd_word_o  (cmd_word_o),
        .cmd_valid_o (cmd_valid_o),
        .bit_cnt_o   (bit_cnt)
    );
endmodule

// File: rtl/dss_chk.sv
module dss_chk #(
    parameter int FRAME_W = 17,
    parameter int CNT_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_s,
    input logic             rise_w,
    input logic             fall_w,
    input logic             rsp_load_i,
    input logic             ser_dout_o,
    input logic             cmd_valid_o,
    input logic [CNT_W-1:0] bit_cnt
);
    p_valid_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    p_valid_after_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> $past(rise_w));

    p_count_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_W - 1));

    p_revert_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> ser_dout_o);

    p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_s && bit_cnt != '0) |=> (bit_cnt == '0));

    p_dout_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s && !fall_w && !rise_w && !rsp_load_i) |=> $stable(ser_dout_o));
endmodule

bind dbg_serial_slave dss_chk #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_s       (sel_s),
    .rise_w      (rise_w),
    .fall_w      (fall_w),
    .rsp_load_i  (rsp_load_i),
    .ser_dout_o  (ser_dout_o),
    .cmd_valid_o (cmd_valid_o),
    .bit_cnt     (bit_cnt)
);

// File: tb/dbg_serial_slave_tb_top.sv
module dbg_serial_slave_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_din = 1'b0, ser_sel = 1'b0;
    logic        ser_dout;
    logic [16:0] cmd_word;
    logic        cmd_valid;
    logic [15:0] rsp_data = '0;
    logic        rsp_stat = 1'b0, rsp_load = 1'b0;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [16:0] exp_q [$];

    always #2 clk = ~clk;

    dbg_serial_slave dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_din_i(ser_din),
        .ser_sel_i(ser_sel), .ser_dout_o(ser_dout), .cmd_word_o(cmd_word),
        .cmd_valid_o(cmd_valid), .rsp_data_i(rsp_data), .rsp_stat_i(rsp_stat),
        .rsp_load_i(rsp_load)
    );

    task automatic check(input bit ok, input string tag, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected command for every valid strobe
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected valid (R8 abort)", cmd_word, 17'h0);
            end else begin
                logic [16:0] e;
                e = exp_q.pop_front();
                check(cmd_word == e, "R2 command word", cmd_word, e);
            end
        end
    end

    task automatic load(input logic stat, input logic [15:0] data);
        @(negedge clk);
        rsp_stat = stat; rsp_data = data; rsp_load = 1'b1;
        @(negedge clk);
        rsp_load = 1'b0;
    endtask

    task automatic frame(input logic [16:0] cmd, input int halfp, input bit chk_tx,
                         input logic [16:0] exp_tx, input int mid_load);
        exp_q.push_back(cmd);
        for (int i = 16; i >= 0; i--) begin
            ser_din = cmd[i];
            if (i == mid_load) begin
                rsp_stat = 1'b0; rsp_data = 16'h0000; rsp_load = 1'b1;
                @(negedge clk);
                rsp_load = 1'b0;
            end
            repeat (halfp) @(negedge clk);
            if (chk_tx)
                check(ser_dout == exp_tx[i], $sformatf("R3 R4 R7 R9 tx bit %0d", i),
                      {16'h0, ser_dout}, {16'h0, exp_tx[i]});
            ser_clk = 1'b1;
            repeat (halfp) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    n_chk++; n_fail++;
                    $display("FAIL watchdog actual=hung expected=finish");
                    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
                    $finish;
                end
            end
        join_none

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        ser_sel = 1'b1;
        repeat (4) @(negedge clk);
        check(ser_dout == 1'b1, "R1 dout after reset", {16'h0, ser_dout}, 17'h1);
        check(cmd_valid == 1'b0, "R1 valid after reset", {16'h0, cmd_valid}, 17'h0);
        check(cmd_word == 17'h0, "R1 word after reset", cmd_word, 17'h0);

        // R5: no load, not-ready word goes out
        frame(17'h1A5C3, 6, 1'b1, 17'h10000, -1);

        // R3 R4: loaded data word
        load(1'b0, 16'hBEEF);
        @(negedge clk);
        check(ser_dout == 1'b0, "R3 status bit after load", {16'h0, ser_dout}, 17'h0);
        frame(17'h01234, 6, 1'b1, 17'h0BEEF, -1);
        check(ser_dout == 1'b1, "R6 not-ready after frame", {16'h0, ser_dout}, 17'h1);

        // R7: load in mid-frame ignored
        load(1'b1, 16'h8001);
        frame(17'h0C3A5, 6, 1'b1, 17'h18001, 8);

        // R8: abort
        load(1'b0, 16'h5555);
        for (int i = 16; i >= 11; i--) begin
            ser_din = 1'b1;
            repeat (6) @(negedge clk);
            ser_clk = 1'b1;
            repeat (6) @(negedge clk);
            ser_clk = 1'b0;
        end
        ser_sel = 1'b0;
        repeat (4) begin
            repeat (6) @(negedge clk); ser_clk = 1'b1;
            repeat (6) @(negedge clk); ser_clk = 1'b0;
        end
        repeat (6) @(negedge clk);
        check(ser_dout == 1'b1, "R8 not-ready after abort", {16'h0, ser_dout}, 17'h1);
        ser_sel = 1'b1;
        repeat (6) @(negedge clk);
        frame(17'h0F0F0, 6, 1'b1, 17'h10000, -1);

        // back-to-back, extreme patterns
        load(1'b0, 16'hFFFF);
        frame(17'h1FFFF, 5, 1'b1, 17'h0FFFF, -1);
        load(1'b1, 16'hA5A5);
        frame(17'h00000, 5, 1'b1, 17'h1A5A5, -1);

        // R10: fastest serial clock, receive path
        frame(17'h15A5A, 1, 1'b0, 17'h0, -1);
        frame(17'h0A5A5, 1, 1'b0, 17'h0, -1);

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R2 R10 all commands seen", 17'(exp_q.size()), 17'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule